// File: doc/BRIEF.md
# Redundant-Binary Digit-Pair Partial Product Cell

This cell is the smallest building block of a signed multiplier that works on redundant binary (RB) numbers. It takes a two-digit slice of the multiplicand and a two-digit slice of the multiplier. Each digit takes a value of -1, 0 or +1. The digit is carried on two rails, a positive-weight bit and a negative-weight bit, and its value is the positive bit minus the negative bit. The cell turns each slice into a 3-bit two's-complement number in the range -3 to +3. It does this with a fixed three-gate formula and assumes no incoming carry. The slices never interact, so every slice of a wide operand is converted at the same time.

The converted multiplier picks a signed multiple of the converted multiplicand. The cell returns that multiple as a four-digit RB partial product, on a positive rail vector and a negative rail vector. No product is ever summed. The soft multiples (±1, ±2) and the hard multiple (±3) are all made by routing multiplicand bits onto the two rails. A parent multiplier places several of these cells side by side and merges their outputs with carry-free RB adders.

Top module: `rb_pp_gen`

## Requirements
- R1: `mcand_tc` equals the two's-complement value 2·r1 + r0 of the multiplicand slice. The high digit r1 is on rail bit 1 and the low digit r0 is on rail bit 0. A digit's rails (pos, neg) read 00 = 0, 10 = +1 and 01 = -1. The code 11 is never applied.
- R2: `mplier_tc` equals the two's-complement value of the multiplier slice, using the same encoding as R1.
- R3: The partial product has value Σ (pp_pos[i] − pp_neg[i])·2^i. This value equals the integer product of the two slice values for all 81 combinations of digit encodings.
- R4: A multiplier slice of value 0 drives both rail vectors to 0000.
- R5: For a multiplier value of +1 or +2, `pp_neg` is {a_sign,000}. For -1 or -2, `pp_pos` is {a_sign,000}. Here a_sign is bit 2 of `mcand_tc`.
- R6: For a multiplier value of +2, `pp_pos` is {0, mcand_tc[1:0], 0}. A multiplicand of -2 times a multiplier of +2 gives the value -4.
- R7: For a multiplier value of -3, `pp_pos` is {a_sign, a_sign, mcand_tc[1:0]} and `pp_neg` is {mcand_tc[1:0], 00}. A multiplicand of -2 times -3 gives 1110 / 1000.
- R8: For every multiplicand value, the rails produced for a multiplier value -m are the rails for +m with `pp_pos` and `pp_neg` exchanged.
- R9: The multiplicand sign bit always occupies the most significant negative-weight position. That position is `pp_neg[3]` for a positive multiplier and `pp_pos[3]` for a negative one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand_pos | input | 2 | Positive-weight rails of the two multiplicand digits |
| mcand_neg | input | 2 | Negative-weight rails of the two multiplicand digits |
| mplier_pos | input | 2 | Positive-weight rails of the two multiplier digits |
| mplier_neg | input | 2 | Negative-weight rails of the two multiplier digits |
| mcand_tc | output | 3 | Multiplicand slice in two's complement |
| mplier_tc | output | 3 | Multiplier slice in two's complement |
| pp_pos | output | 4 | Positive-weight rails of the partial product |
| pp_neg | output | 4 | Negative-weight rails of the partial product |

## Verification
The cell has no state, so any fault shows at the ports as soon as the inputs settle. A bad conversion gate appears directly on `mcand_tc` or `mplier_tc`. It also appears as a wrong product value, but only for the encodings that exercise that gate, which is why every redundant pair is applied. A wrong multiple selection or a rail swap can keep the product value right and still break the fixed rail layout. For that reason the exact rails for ±2 and -3, the sign position, and the mirror relation between +m and -m are all checked, not just the arithmetic value.

// File: rtl/rb_pp_gen.sv
module rb_pp_gen (
  input  logic [1:0] mcand_pos,
  input  logic [1:0] mcand_neg,
  input  logic [1:0] mplier_pos,
  input  logic [1:0] mplier_neg,
  output logic [2:0] mcand_tc,
  output logic [2:0] mplier_tc,
  output logic [3:0] pp_pos,
  output logic [3:0] pp_neg
);

  assign mcand_tc[0]  = mcand_pos[0] | mcand_neg[0];
  assign mcand_tc[1]  = mcand_neg[0] ^ (mcand_pos[1] | mcand_neg[1]);
  assign mcand_tc[2]  = ~mcand_pos[1] & (mcand_neg[0] | mcand_neg[1]);

  assign mplier_tc[0] = mplier_pos[0] | mplier_neg[0];
  assign mplier_tc[1] = mplier_neg[0] ^ (mplier_pos[1] | mplier_neg[1]);
  assign mplier_tc[2] = ~mplier_pos[1] & (mplier_neg[0] | mplier_neg[1]);

  always_comb begin
    logic [3:0] fwd, bwd;
    logic       sgn;
    int         acc, a_ref, b_ref;
    sgn = mcand_tc[2];
    fwd = 4'b0000;
    bwd = 4'b0000;
    unique case (mplier_tc)
      3'b001, 3'b111: begin fwd = {1'b0, mcand_tc};              bwd = {sgn, 3'b000}; end
      3'b010, 3'b110: begin fwd = {1'b0, mcand_tc[1:0], 1'b0};   bwd = {sgn, 3'b000}; end
      3'b011, 3'b101: begin fwd = {mcand_tc[1:0], 2'b00};        bwd = {sgn, mcand_tc}; end
      default:        begin fwd = 4'b0000;                       bwd = 4'b0000; end
    endcase
    if (mplier_tc[2]) begin
      pp_pos = bwd;
      pp_neg = fwd;
    end else begin
      pp_pos = fwd;
      pp_neg = bwd;
    end

    acc = 0;
    for (int i = 0; i < 4; i++) acc += (int'(pp_pos[i]) - int'(pp_neg[i])) * (1 << i);
    a_ref = 2 * (int'(mcand_pos[1]) - int'(mcand_neg[1])) + int'(mcand_pos[0]) - int'(mcand_neg[0]);
    b_ref = 2 * (int'(mplier_pos[1]) - int'(mplier_neg[1])) + int'(mplier_pos[0]) - int'(mplier_neg[0]);

    p_conv_mcand_r1: assert (int'($signed(mcand_tc)) == a_ref) else $error("R1 conversion");
    p_conv_mplier_r2: assert (int'($signed(mplier_tc)) == b_ref) else $error("R2 conversion");
    p_value_r3: assert (acc == a_ref * b_ref) else $error("R3 product value");
    p_zero_r4: assert (b_ref != 0 || (pp_pos == 4'b0000 && pp_neg == 4'b0000)) else $error("R4 zero");
    p_sign_rail_r9: assert (b_ref == 0 || (b_ref > 0 ? pp_neg[3] == sgn : pp_pos[3] == sgn))
      else $error("R9 sign placement");
  end

endmodule

// File: tb/tb_rb_pp_gen.sv
module tb_rb_pp_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] mcand_pos = '0, mcand_neg = '0, mplier_pos = '0, mplier_neg = '0;
  logic [2:0] mcand_tc, mplier_tc;
  logic [3:0] pp_pos, pp_neg;

  rb_pp_gen dut (
    .mcand_pos(mcand_pos), .mcand_neg(mcand_neg),
    .mplier_pos(mplier_pos), .mplier_neg(mplier_neg),
    .mcand_tc(mcand_tc), .mplier_tc(mplier_tc),
    .pp_pos(pp_pos), .pp_neg(pp_neg)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] sp [7][7];
  logic [3:0] sn [7][7];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dval(input int d);
    return (d == 1) ? 1 : ((d == 2) ? -1 : 0);
  endfunction

  function automatic int rbval(input logic [3:0] p, input logic [3:0] n);
    int s = 0;
    for (int i = 0; i < 4; i++) s += (int'(p[i]) - int'(n[i])) * (1 << i);
    return s;
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pp_pos == 4'b0 && pp_neg == 4'b0, "R4 reset", int'({pp_pos, pp_neg}), 0);
    chk(mcand_tc == 3'b0 && mplier_tc == 3'b0, "R1 reset", int'({mcand_tc, mplier_tc}), 0);

    for (int ia = 0; ia < 9; ia++) begin
      for (int ib = 0; ib < 9; ib++) begin
        int av, bv, pv;
        logic [2:0] at;
        @(posedge clk);
        mcand_pos  = {1'(ia / 3 == 1), 1'(ia % 3 == 1)};
        mcand_neg  = {1'(ia / 3 == 2), 1'(ia % 3 == 2)};
        mplier_pos = {1'(ib / 3 == 1), 1'(ib % 3 == 1)};
        mplier_neg = {1'(ib / 3 == 2), 1'(ib % 3 == 2)};
        av = 2 * dval(ia / 3) + dval(ia % 3);
        bv = 2 * dval(ib / 3) + dval(ib % 3);
        at = 3'(av);
        @(negedge clk);
        chk(mcand_tc == at, "R1", int'(mcand_tc), int'(at));
        chk(mplier_tc == 3'(bv), "R2", int'(mplier_tc), int'(3'(bv)));
        pv = rbval(pp_pos, pp_neg);
        chk(pv == av * bv, "R3", pv, av * bv);
        if (bv == 0)
          chk(pp_pos == 4'b0 && pp_neg == 4'b0, "R4", int'({pp_pos, pp_neg}), 0);
        if (bv == 1 || bv == 2)
          chk(pp_neg == {at[2], 3'b000}, "R5", int'(pp_neg), int'({at[2], 3'b000}));
        if (bv == -1 || bv == -2)
          chk(pp_pos == {at[2], 3'b000}, "R5", int'(pp_pos), int'({at[2], 3'b000}));
        if (bv == 2)
          chk(pp_pos == {1'b0, at[1:0], 1'b0}, "R6", int'(pp_pos), int'({1'b0, at[1:0], 1'b0}));
        if (bv == -3) begin
          chk(pp_pos == {at[2], at[2], at[1:0]}, "R7 pos", int'(pp_pos), int'({at[2], at[2], at[1:0]}));
          chk(pp_neg == {at[1:0], 2'b00}, "R7 neg", int'(pp_neg), int'({at[1:0], 2'b00}));
        end
        if (bv > 0) chk(pp_neg[3] == at[2], "R9", int'(pp_neg[3]), int'(at[2]));
        if (bv < 0) chk(pp_pos[3] == at[2], "R9", int'(pp_pos[3]), int'(at[2]));
        if (av == -2 && bv == 2)
          chk(pv == -4, "R6 example", pv, -4);
        if (av == -2 && bv == -3)
          chk(pp_pos == 4'b1110 && pp_neg == 4'b1000, "R7 example",
              int'({pp_pos, pp_neg}), int'(8'b1110_1000));
        sp[av + 3][bv + 3] = pp_pos;
        sn[av + 3][bv + 3] = pp_neg;
      end
    end

    for (int a = 0; a < 7; a++) begin
      for (int m = 1; m <= 3; m++) begin
        chk(sp[a][3 - m] == sn[a][3 + m] && sn[a][3 - m] == sp[a][3 + m], "R8",
            int'({sp[a][3 - m], sn[a][3 - m]}), int'({sn[a][3 + m], sp[a][3 + m]}));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule